// File: doc/BRIEF.md
# Dual Converter Trigger Dispatcher

This block takes the start requests for a pair of data converters and turns them into one start pulse per converter. A request comes from either a hardware start event or a software trigger. The block decides which converter, or both, receives each request. It uses three inputs to decide: a pairing enable, a routing mode code and a free-running flag.

When pairing is off, every request goes to the primary converter. When pairing is on, the mode code picks one of two routings. In simultaneous routing each request starts both converters. In alternating routing, successive requests go to the primary converter and then the secondary one, in turn. Alternating routing is only meaningful with single conversions. If it is selected while free-running is on, the block falls back to simultaneous routing and latches a configuration error flag.

Top module: `dual_trig_dispatch`

## Requirements
- R1: After reset, `start_pri`, `start_sec` and `cfg_err` are all 0.
- R2: A request is the rising edge of (`start_evt` OR `sw_trig`). The start pulse(s) it produces appear in the cycle after the edge. A start event and a software trigger in the same cycle count as one request. A request held high for several cycles counts as one request.
- R3: Each start pulse is high for exactly one clock cycle.
- R4: With `pair_en` = 0, every request starts only the primary converter, whatever `mode` and `free_run` are.
- R5: With `pair_en` = 1 and `mode` = 0, every request starts both converters in the same cycle.
- R6: With `pair_en` = 1, mode codes 2 and 3 behave exactly like code 0.
- R7: With `pair_en` = 1, `mode` = 1 and `free_run` = 0, successive requests alternate between the converters. The first request after the alternation pointer is cleared goes to the primary converter.
- R8: The alternation pointer returns to the primary converter on reset. It also returns to the primary converter whenever `mode` or `pair_en` differs from its value in the previous cycle. A request in the cycle of such a change goes to the primary converter.
- R9: With `pair_en` = 1, `mode` = 1 and `free_run` = 1, requests start both converters. `cfg_err` rises in the following cycle and stays at 1 until reset.
- R10: With `pair_en` = 0, no setting of `mode` and `free_run` sets `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_evt | input | 1 | Hardware start event |
| sw_trig | input | 1 | Software start trigger |
| mode | input | 2 | Routing mode: 0 simultaneous, 1 alternating, 2 and 3 act as 0 |
| pair_en | input | 1 | Secondary converter paired with the primary |
| free_run | input | 1 | Converters run in free-running conversion |
| start_pri | output | 1 | One-cycle start pulse to the primary converter |
| start_sec | output | 1 | One-cycle start pulse to the secondary converter |
| cfg_err | output | 1 | Sticky flag: alternating routing was selected while free-running |

## Verification
The bench runs a full sweep over pairing enable, all four mode codes and the free-running flag. Under each setting it issues several requests from the event input alone, from the software input alone, and from both inputs together. This separates the routings from one another and shows that both sources are treated alike. The sweep also checks that alternation advances only in the one valid configuration, and that the error flag latches only there. Further patterns cover other cases. A request held for several cycles must give one pulse, which separates edge detection from level triggering. A mode change that leaves no request in between must clear the alternation pointer. The final reset must clear the sticky flag.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;

    localparam int MODE_W = 2;

    // Mode code selecting alternating routing; every other code is simultaneous.
    localparam logic [MODE_W-1:0] MODE_ALT_CODE = MODE_W'(1);

    typedef enum logic [1:0] {
        ROUTE_PRI  = 2'd0,
        ROUTE_BOTH = 2'd1,
        ROUTE_ALT  = 2'd2
    } route_e;

    typedef struct packed {
        logic              ptr;
        logic              pri;
        logic              sec;
        logic              err;
        logic [MODE_W-1:0] mode;
        logic              pair;
    } seq_state_t;

endpackage

// File: rtl/tdisp_edge.sv
module tdisp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_a,
    input  logic trig_b,
    output logic pulse
);

    logic any_req;
    logic prev_d;
    logic prev_q;

    always_comb begin
        any_req = trig_a | trig_b;
        pulse   = any_req & ~prev_q;
        prev_d  = any_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/tdisp_route.sv
module tdisp_route
    import tdisp_pkg::*;
#(
    parameter int                MODE_W   = tdisp_pkg::MODE_W,
    parameter logic [MODE_W-1:0] ALT_CODE = MODE_W'(1)
) (
    input  logic              pair_en,
    input  logic [MODE_W-1:0] mode,
    input  logic              free_run,
    output route_e            route,
    output logic              cfg_bad
);

    always_comb begin
        route   = ROUTE_PRI;
        cfg_bad = 1'b0;
        if (pair_en) begin
            if (mode == ALT_CODE) begin
                if (free_run) begin
                    route   = ROUTE_BOTH;
                    cfg_bad = 1'b1;
                end else begin
                    route   = ROUTE_ALT;
                end
            end else begin
                route = ROUTE_BOTH;
            end
        end
    end

    always_comb begin
        assert_unpaired_clean_R10: assert (pair_en || (!cfg_bad && route == ROUTE_PRI));
    end

endmodule

// File: rtl/tdisp_seq.sv
module tdisp_seq
    import tdisp_pkg::*;
#(
    parameter int MODE_W = tdisp_pkg::MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse,
    input  route_e            route,
    input  logic              cfg_bad,
    input  logic [MODE_W-1:0] mode,
    input  logic              pair_en,
    output logic              start_pri,
    output logic              start_sec,
    output logic              cfg_err
);

    seq_state_t st_d;
    seq_state_t st_q;
    logic       cfg_chg;
    logic       ptr_eff;

    always_comb begin
        st_d      = st_q;
        cfg_chg   = (mode != st_q.mode) || (pair_en != st_q.pair);
        ptr_eff   = cfg_chg ? 1'b0 : st_q.ptr;
        st_d.mode = mode;
        st_d.pair = pair_en;
        st_d.ptr  = ptr_eff;
        st_d.pri  = 1'b0;
        st_d.sec  = 1'b0;
        st_d.err  = st_q.err | cfg_bad;
        if (pulse) begin
            case (route)
                ROUTE_BOTH: begin
                    st_d.pri = 1'b1;
                    st_d.sec = 1'b1;
                end
                ROUTE_ALT: begin
                    st_d.pri = ~ptr_eff;
                    st_d.sec = ptr_eff;
                    st_d.ptr = ~ptr_eff;
                end
                default: st_d.pri = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_pri = st_q.pri;
    assign start_sec = st_q.sec;
    assign cfg_err   = st_q.err;

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pri || start_sec) |=> (!start_pri && !start_sec));

    assert_pri_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && route == ROUTE_PRI) |=> (start_pri && !start_sec));

    assert_alt_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && route == ROUTE_ALT) |=> (start_pri ^ start_sec));

    assert_sticky_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_caused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pri || start_sec) |-> $past(pulse));

endmodule

// File: rtl/dual_trig_dispatch.sv
module dual_trig_dispatch
    import tdisp_pkg::*;
#(
    parameter int                MODE_W   = tdisp_pkg::MODE_W,
    parameter logic [MODE_W-1:0] ALT_CODE = MODE_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              sw_trig,
    input  logic [MODE_W-1:0] mode,
    input  logic              pair_en,
    input  logic              free_run,
    output logic              start_pri,
    output logic              start_sec,
    output logic              cfg_err
);

    logic   req_pulse;
    route_e route;
    logic   cfg_bad;

    tdisp_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_a (start_evt),
        .trig_b (sw_trig),
        .pulse  (req_pulse)
    );

    tdisp_route #(
        .MODE_W   (MODE_W),
        .ALT_CODE (ALT_CODE)
    ) u_route (
        .pair_en  (pair_en),
        .mode     (mode),
        .free_run (free_run),
        .route    (route),
        .cfg_bad  (cfg_bad)
    );

    tdisp_seq #(
        .MODE_W (MODE_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse     (req_pulse),
        .route     (route),
        .cfg_bad   (cfg_bad),
        .mode      (mode),
        .pair_en   (pair_en),
        .start_pri (start_pri),
        .start_sec (start_sec),
        .cfg_err   (cfg_err)
    );

    assert_unpaired_sec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_sec |-> $past(pair_en));

endmodule

// File: tb/dual_trig_dispatch_bench.sv
module dual_trig_dispatch_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_evt = 1'b0;
    logic       sw_trig = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       pair_en = 1'b0;
    logic       free_run = 1'b0;
    logic       start_pri;
    logic       start_sec;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic       m_ptr = 1'b0;
    logic       m_err = 1'b0;
    logic [1:0] m_mode = 2'd0;
    logic       m_pair = 1'b0;

    always #5 clk = ~clk;

    dual_trig_dispatch u_dual_trig_dispatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .sw_trig   (sw_trig),
        .mode      (mode),
        .pair_en   (pair_en),
        .free_run  (free_run),
        .start_pri (start_pri),
        .start_sec (start_sec),
        .cfg_err   (cfg_err)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {pri,sec,err} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply configuration at a negedge; the model tracks pointer clearing.
    task automatic set_cfg(input logic p, input logic [1:0] m, input logic fr);
        @(negedge clk);
        pair_en  = p;
        mode     = m;
        free_run = fr;
        if (p != m_pair || m != m_mode) m_ptr = 1'b0;
        m_pair = p;
        m_mode = m;
        if (p && m == 2'd1 && fr) m_err = 1'b1;
        @(negedge clk);
    endtask

    // One request: pulse visible the cycle after, gone the cycle after that.
    task automatic request(input logic ev, input logic sw, input string req);
        logic ep;
        logic es;
        @(negedge clk);
        start_evt = ev;
        sw_trig   = sw;
        if (!pair_en) begin
            ep = 1'b1; es = 1'b0;
        end else if (mode == 2'd1 && !free_run) begin
            ep = ~m_ptr; es = m_ptr; m_ptr = ~m_ptr;
        end else begin
            ep = 1'b1; es = 1'b1;
        end
        @(negedge clk);
        check(req, {start_pri, start_sec, cfg_err}, {ep, es, m_err});
        start_evt = 1'b0;
        sw_trig   = 1'b0;
        @(negedge clk);
        check("R3", {start_pri, start_sec, cfg_err}, {1'b0, 1'b0, m_err});
    endtask

    function automatic string tag(input logic p, input logic [1:0] m, input logic fr);
        if (!p)               return "R4";
        if (m == 2'd1 && fr)  return "R9";
        if (m == 2'd1)        return "R7";
        if (m == 2'd0)        return "R5";
        return "R6";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {start_pri, start_sec, cfg_err}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {start_pri, start_sec, cfg_err}, 3'b000);

        // R10: unpaired sweep first so the sticky flag is still clear
        for (int m = 0; m < 4; m++) begin
            for (int fr = 0; fr < 2; fr++) begin
                set_cfg(1'b0, 2'(m), 1'(fr));
                request(1'b1, 1'b0, "R4");
                check("R10", {1'b0, 1'b0, cfg_err}, 3'b000);
            end
        end

        // R2: held request gives one pulse
        set_cfg(1'b1, 2'd0, 1'b0);
        @(negedge clk);
        start_evt = 1'b1;
        @(negedge clk);
        check("R2", {start_pri, start_sec, cfg_err}, {1'b1, 1'b1, m_err});
        @(negedge clk);
        check("R2", {start_pri, start_sec, cfg_err}, {1'b0, 1'b0, m_err});
        @(negedge clk);
        check("R2", {start_pri, start_sec, cfg_err}, {1'b0, 1'b0, m_err});
        start_evt = 1'b0;

        // R8: pointer cleared by a mode change with no request in between
        set_cfg(1'b1, 2'd1, 1'b0);
        request(1'b1, 1'b0, "R7");
        set_cfg(1'b1, 2'd0, 1'b0);
        set_cfg(1'b1, 2'd1, 1'b0);
        request(1'b0, 1'b1, "R8");
        request(1'b0, 1'b1, "R8");
        set_cfg(1'b0, 2'd1, 1'b0);
        set_cfg(1'b1, 2'd1, 1'b0);
        request(1'b1, 1'b1, "R8");

        // Full paired sweep
        for (int m = 0; m < 4; m++) begin
            for (int fr = 0; fr < 2; fr++) begin
                set_cfg(1'b1, 2'(m), 1'(fr));
                for (int k = 0; k < 3; k++) begin
                    request(1'b1, 1'b0, tag(1'b1, 2'(m), 1'(fr)));
                    request(1'b0, 1'b1, tag(1'b1, 2'(m), 1'(fr)));
                    request(1'b1, 1'b1, tag(1'b1, 2'(m), 1'(fr)));
                end
            end
        end

        // R9: flag stays set after leaving the bad configuration
        set_cfg(1'b0, 2'd0, 1'b0);
        check("R9", {1'b0, 1'b0, cfg_err}, 3'b001);

        // R1: reset clears the sticky flag and the pointer
        rst_n = 1'b0;
        m_err = 1'b0;
        m_ptr = 1'b0;
        m_pair = 1'b0;
        m_mode = 2'd0;
        @(negedge clk);
        check("R1", {start_pri, start_sec, cfg_err}, 3'b000);
        rst_n = 1'b1;
        set_cfg(1'b1, 2'd1, 1'b0);
        request(1'b1, 1'b0, "R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule